// File: doc/BRIEF.md
# IF Feedback VGA Control-Code Calculator

This block closes the digital half of an intermediate-frequency gain loop. After a start strobe it gathers sixteen readings from the IF power detector ADC and averages them. From the average it computes the next 12-bit code for the DAC that sets the variable-gain amplifier's control voltage, so that the IF output power moves toward a fixed target. The block keeps the present control code in a register. That register is loaded from a programmable initial code while reset is asserted, and each completed measurement updates it.

The loop model is linear. Amplifier gain rises by 50 dB per volt of control voltage. Detector voltage rises by 0.05 V per dBm of output power, and the target of -19 dBm sits at a detector voltage of 1.625 V. Together these give a one-step correction of (Vdet - 1.625 V) / 2.5 V, which is subtracted from the present control voltage. The correction is used only when the averaged reading lies in the detector's trusted range of 0.375 V to 2.75 V. Outside that range the block moves the code by a fixed programmable step in the direction that brings the reading back into range, and it flags a retry so that the sequencer measures again.

All values are in codes. With the default parameters the ADC code is 4 mV per LSB and the DAC code is 1 mV per LSB. The window limits are ADC codes 94 and 688, and the target is ADC code 406. The correction factor of 1.6 DAC codes per ADC code is approximated as 205/128. When the input envelope is not constant, the sequencer raises a flag and accepted samples are then spaced about 6.68 µs apart.

Top module: `vga_fb_calc`

## Requirements
- R1: While reset is low at a clock edge, `dac_code` takes the value of `init_code`, and `dac_wr`, `done` and `retry` are low.
- R2: A measurement accepts exactly 16 detector samples. The average is the 14-bit sum shifted right by 4, so fractions are truncated. No `done` appears before the 16th sample has been accepted.
- R3: When the average A satisfies 94 <= A <= 688, the new code is the present code minus D, where D = floor(((A - 406) * 205 + 64) / 128).
- R4: The window limits are inclusive. An average of exactly 94 or exactly 688 uses the R3 correction, and 93 or 689 does not.
- R5: When the average is below 94, the new code is the present code plus `nudge_step`, and `retry` is high with `done`.
- R6: When the average is above 688, the new code is the present code minus `nudge_step`, and `retry` is high with `done`.
- R7: The result saturates at 0 and 4095. It never wraps, either after a correction or after a nudge.
- R8: `done` and `dac_wr` are high together for exactly one cycle per measurement. `dac_code` changes only in a cycle where `dac_wr` is high.
- R9: When `env_slow` is high at start, a valid sample is ignored if it arrives fewer than 669 cycles (GAP_CYC + 1) after the previously accepted sample. When `env_slow` is low, back-to-back samples are all accepted.
- R10: A `start` pulse during a measurement is ignored, and `det_valid` pulses while no measurement is running are ignored.
- R11: `retry` is low whenever the average is inside the window, and it is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads `init_code` |
| init_code | input | 12 | Control code taken on reset |
| nudge_step | input | 12 | Code step used when the reading is out of window |
| start | input | 1 | Begin one measurement (pulse) |
| env_slow | input | 1 | Input envelope is not constant; spaces the samples |
| det_valid | input | 1 | `det_sample` carries a new detector reading |
| det_sample | input | 10 | Detector ADC code |
| dac_code | output | 12 | Present VGA control code |
| dac_wr | output | 1 | One-cycle request to write `dac_code` to the DAC |
| retry | output | 1 | The reading was out of window; measure again |
| done | output | 1 | One-cycle end-of-measurement pulse |

## Verification
The assertions check the following on every cycle: `done` is a single-cycle pulse that arrives together with `dac_wr`; the code never moves without a write; `retry` never appears without `done`; every finished average leads to a write on the next cycle; and a nudge never moves the code by more than the programmed step. Only the bench's scenarios can show the numeric results. Those are the rounded one-step correction, the inclusive window edges, saturation at both ends of the code range, truncation of mixed-value averages, and the rejection of early samples in slow-envelope mode. The scenarios also cover a stray start during a measurement and samples that arrive while the block is idle.

// File: rtl/vga_fb_pkg.sv
// Shared types for the IF feedback VGA control-code calculator.
// Assumes: none beyond the consumers agreeing on these encodings.
package vga_fb_pkg;

    // Sequencer state: waiting for a start, or collecting samples.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MEAS = 1'b1
    } seq_state_t;

    // Where the averaged detector reading falls relative to the trusted range.
    typedef enum logic [1:0] {
        WIN_INSIDE = 2'd0,
        WIN_BELOW  = 2'd1,
        WIN_ABOVE  = 2'd2
    } win_class_t;

endpackage

// File: rtl/vga_fb_avg.sv
// Detector averager: collects 2**NAVG_LOG2 accepted samples and presents
// their sum divided by the count (truncated), with a one-cycle valid pulse.
// In slow-envelope mode an accepted sample opens a hold-off of GAP_CYC
// cycles during which further samples are dropped.
// Assumes: clear is a single-cycle pulse at the start of a measurement;
// avg is meaningful in the cycle avg_vld is high and stays until the next clear.
module vga_fb_avg #(
    parameter int ADC_W     = 10,
    parameter int NAVG_LOG2 = 4,
    parameter int GAP_CYC   = 668
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             active,
    input  logic             slow,
    input  logic             smp_valid,
    input  logic [ADC_W-1:0] smp,
    output logic             avg_vld,
    output logic [ADC_W-1:0] avg
);
    localparam int SW = ADC_W + NAVG_LOG2;
    localparam int GW = (GAP_CYC > 0) ? $clog2(GAP_CYC + 1) : 1;

    logic [SW-1:0]        sum_q;
    logic [NAVG_LOG2-1:0] cnt_q;
    logic                 vld_q;
    logic                 gap_ok;
    logic                 take;

    // A sample counts only inside a measurement, outside any hold-off,
    // and not after the set is complete.
    assign take = active && smp_valid && gap_ok && !vld_q;

    // Running sum, sample count and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            cnt_q <= '0;
            vld_q <= 1'b0;
        end else if (clear) begin
            sum_q <= '0;
            cnt_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (take) begin
                sum_q <= sum_q + SW'(smp);
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == '1) begin
                    vld_q <= 1'b1;
                end
            end
        end
    end

    generate
        if (GAP_CYC > 0) begin : g_gap
            logic [GW-1:0] gap_q;

            // Hold-off counter, loaded after each accepted sample in slow mode.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    gap_q <= '0;
                end else if (take && slow) begin
                    gap_q <= GW'(GAP_CYC);
                end else if (gap_q != '0) begin
                    gap_q <= gap_q - 1'b1;
                end
            end

            assign gap_ok = (gap_q == '0);
        end else begin : g_nogap
            logic unused_slow;
            assign unused_slow = slow;
            assign gap_ok      = 1'b1;
        end
    endgenerate

    assign avg_vld = vld_q;
    assign avg     = sum_q[SW-1:NAVG_LOG2];

endmodule

// File: rtl/vga_fb_step.sv
// Next-code calculator (combinational). Classifies the averaged detector
// code against the trusted window. Inside the window it subtracts the
// rounded linear correction (avg - target) * CORR_NUM / 2**CORR_SHIFT;
// outside it moves by +/- step. The result is clamped to the DAC range.
// Assumes: CORR_SHIFT >= 1 and DET_LO <= DET_TGT <= DET_HI.
module vga_fb_step
    import vga_fb_pkg::*;
#(
    parameter int ADC_W      = 10,
    parameter int DAC_W      = 12,
    parameter int DET_LO     = 94,
    parameter int DET_HI     = 688,
    parameter int DET_TGT    = 406,
    parameter int CORR_NUM   = 205,
    parameter int CORR_SHIFT = 7
) (
    input  logic [DAC_W-1:0] cur_code,
    input  logic [ADC_W-1:0] avg,
    input  logic [DAC_W-1:0] step,
    output logic [DAC_W-1:0] next_code,
    output win_class_t       win
);
    localparam int WW = DAC_W + ADC_W + $clog2(CORR_NUM + 1) + 4;
    localparam logic signed [WW-1:0] K_TGT  = WW'(DET_TGT);
    localparam logic signed [WW-1:0] K_NUM  = WW'(CORR_NUM);
    localparam logic signed [WW-1:0] K_HALF = WW'(1) <<< (CORR_SHIFT - 1);
    localparam logic signed [WW-1:0] K_MAX  = WW'((1 << DAC_W) - 1);
    localparam logic [ADC_W-1:0]     A_LO   = ADC_W'(DET_LO);
    localparam logic [ADC_W-1:0]     A_HI   = ADC_W'(DET_HI);

    logic signed [WW-1:0] cur_w, avg_w, step_w;
    logic signed [WW-1:0] err, prod, delta, raw;

    // Widen the unsigned codes into one signed working width.
    always_comb begin
        cur_w  = $signed({{(WW-DAC_W){1'b0}}, cur_code});
        avg_w  = $signed({{(WW-ADC_W){1'b0}}, avg});
        step_w = $signed({{(WW-DAC_W){1'b0}}, step});
    end

    // Classify the reading against the inclusive trusted window.
    always_comb begin
        if (avg < A_LO) begin
            win = WIN_BELOW;
        end else if (avg > A_HI) begin
            win = WIN_ABOVE;
        end else begin
            win = WIN_INSIDE;
        end
    end

    // Rounded linear correction, then the unclamped candidate code.
    always_comb begin
        err   = avg_w - K_TGT;
        prod  = err * K_NUM;
        delta = (prod + K_HALF) >>> CORR_SHIFT;
        case (win)
            WIN_BELOW: raw = cur_w + step_w;
            WIN_ABOVE: raw = cur_w - step_w;
            default:   raw = cur_w - delta;
        endcase
    end

    // Saturate to the DAC code range.
    always_comb begin
        if (raw < 0) begin
            next_code = '0;
        end else if (raw > K_MAX) begin
            next_code = '1;
        end else begin
            next_code = raw[DAC_W-1:0];
        end
    end

endmodule

// File: rtl/vga_fb_calc.sv
// Top of the IF feedback VGA control-code calculator. A start strobe begins
// one measurement: the averager gathers the detector samples, the step
// calculator derives the next code, and the result is registered together
// with single-cycle write and done pulses, plus retry when out of window.
// Assumes: init_code is steady while reset is held; nudge_step is steady
// during a measurement.
module vga_fb_calc
    import vga_fb_pkg::*;
#(
    parameter int ADC_W      = 10,
    parameter int DAC_W      = 12,
    parameter int NAVG_LOG2  = 4,
    parameter int GAP_CYC    = 668,
    parameter int DET_LO     = 94,
    parameter int DET_HI     = 688,
    parameter int DET_TGT    = 406,
    parameter int CORR_NUM   = 205,
    parameter int CORR_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DAC_W-1:0] init_code,
    input  logic [DAC_W-1:0] nudge_step,
    input  logic             start,
    input  logic             env_slow,
    input  logic             det_valid,
    input  logic [ADC_W-1:0] det_sample,
    output logic [DAC_W-1:0] dac_code,
    output logic             dac_wr,
    output logic             retry,
    output logic             done
);
    seq_state_t       state_q;
    logic             slow_q;
    logic             go;
    logic             avg_vld;
    logic [ADC_W-1:0] avg_val;
    logic [DAC_W-1:0] next_code;
    win_class_t       win;
    logic [DAC_W-1:0] code_q;
    logic             wr_q, done_q, retry_q;

    // A start only counts while idle.
    assign go = start && (state_q == ST_IDLE);

    // Sequencer: idle until start, measure until the average is ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slow_q  <= 1'b0;
        end else if (go) begin
            state_q <= ST_MEAS;
            slow_q  <= env_slow;
        end else if (avg_vld) begin
            state_q <= ST_IDLE;
        end
    end

    vga_fb_avg #(
        .ADC_W     (ADC_W),
        .NAVG_LOG2 (NAVG_LOG2),
        .GAP_CYC   (GAP_CYC)
    ) u_avg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (go),
        .active    (state_q == ST_MEAS),
        .slow      (slow_q),
        .smp_valid (det_valid),
        .smp       (det_sample),
        .avg_vld   (avg_vld),
        .avg       (avg_val)
    );

    vga_fb_step #(
        .ADC_W      (ADC_W),
        .DAC_W      (DAC_W),
        .DET_LO     (DET_LO),
        .DET_HI     (DET_HI),
        .DET_TGT    (DET_TGT),
        .CORR_NUM   (CORR_NUM),
        .CORR_SHIFT (CORR_SHIFT)
    ) u_step (
        .cur_code  (code_q),
        .avg       (avg_val),
        .step      (nudge_step),
        .next_code (next_code),
        .win       (win)
    );

    // Present control code: loaded on reset, replaced when an average lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= init_code;
        end else if (avg_vld) begin
            code_q <= next_code;
        end
    end

    // Result strobes, each high for the single cycle after the average.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
            retry_q <= 1'b0;
        end else begin
            wr_q    <= avg_vld;
            done_q  <= avg_vld;
            retry_q <= avg_vld && (win != WIN_INSIDE);
        end
    end

    assign dac_code = code_q;
    assign dac_wr   = wr_q;
    assign done     = done_q;
    assign retry    = retry_q;

endmodule

// File: rtl/vga_fb_calc_chk.sv
// Cycle-level checker for vga_fb_calc, bound into every instance.
// Assumes: nudge_step is steady around a nudge result.
module vga_fb_calc_chk #(
    parameter int DAC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DAC_W-1:0] dac_code,
    input logic             dac_wr,
    input logic             done,
    input logic             retry,
    input logic [DAC_W-1:0] nudge_step,
    input logic             avg_vld
);
    // R8: done lasts a single cycle.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the code moves only together with a write strobe.
    p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_wr && $past(rst_n)) |-> $stable(dac_code));

    // R11: retry never appears without done.
    p_retry_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> done);

    // R2: a finished average is followed by a write and done.
    p_avg_to_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld |=> (done && dac_wr));

    // R5 and R6: a nudge moves the code by at most the step.
    p_nudge_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_wr && retry) |->
        (((int'(dac_code) >= int'($past(dac_code)))
            ? (int'(dac_code) - int'($past(dac_code)))
            : (int'($past(dac_code)) - int'(dac_code))) <= int'(nudge_step)));

endmodule

bind vga_fb_calc vga_fb_calc_chk #(.DAC_W(DAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dac_code   (dac_code),
    .dac_wr     (dac_wr),
    .done       (done),
    .retry      (retry),
    .nudge_step (nudge_step),
    .avg_vld    (avg_vld)
);

// File: tb/vga_fb_calc_tb.sv
module vga_fb_calc_tb;
    localparam int GAP = 668;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] init_code = 12'd2048;
    logic [11:0] nudge_step = 12'd64;
    logic        start = 1'b0;
    logic        env_slow = 1'b0;
    logic        det_valid = 1'b0;
    logic [9:0]  det_sample = '0;
    logic [11:0] dac_code;
    logic        dac_wr, retry, done;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    logic [11:0] last_code = '0;
    logic        last_retry = 1'b0;
    logic        last_wr = 1'b0;
    int cycles = 0;

    always #5 clk = ~clk;

    vga_fb_calc u_dut (
        .clk(clk), .rst_n(rst_n), .init_code(init_code), .nudge_step(nudge_step),
        .start(start), .env_slow(env_slow), .det_valid(det_valid),
        .det_sample(det_sample), .dac_code(dac_code), .dac_wr(dac_wr),
        .retry(retry), .done(done)
    );

    // Records the outputs in every cycle where done is high.
    always @(negedge clk) begin
        cycles++;
        if (done) begin
            done_cnt++;
            last_code  = dac_code;
            last_retry = retry;
            last_wr    = dac_wr;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One measurement; even samples carry a, odd samples carry b.
    task automatic meas(input logic [9:0] a, input logic [9:0] b, input logic slow);
        int c0;
        c0 = done_cnt;
        @(negedge clk);
        env_slow = slow;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 16; i++) begin
            if (i == 15) chk("R2 no early done", done_cnt, c0);
            det_valid  = 1'b1;
            det_sample = (i % 2 == 1) ? b : a;
            @(negedge clk);
            det_valid = 1'b0;
            if (slow && i < 15) begin
                repeat (2) @(negedge clk);
                det_valid  = 1'b1;
                det_sample = 10'd1023;
                if (i == 5) start = 1'b1;
                @(negedge clk);
                det_valid = 1'b0;
                start     = 1'b0;
                repeat (GAP) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        chk("R8 one done per measurement", done_cnt - c0, 1);
        chk("R8 write with done", int'(last_wr), 1);
    endtask

    typedef struct packed {
        logic [9:0]  a;
        logic [9:0]  b;
        logic [11:0] code;
        logic        rty;
    } vec_t;

    localparam int NV = 11;
    // Chained from init 2048, step 64.
    localparam vec_t VEC [NV] = '{
        '{10'd406,  10'd406,  12'd2048, 1'b0},  // R3 on target
        '{10'd500,  10'd500,  12'd1897, 1'b0},  // R3 high reading
        '{10'd300,  10'd300,  12'd2067, 1'b0},  // R3 low reading, floor rounding
        '{10'd50,   10'd50,   12'd2131, 1'b1},  // R5 below window
        '{10'd900,  10'd900,  12'd2067, 1'b1},  // R6 above window
        '{10'd94,   10'd94,   12'd2567, 1'b0},  // R4 lower edge inside
        '{10'd688,  10'd688,  12'd2115, 1'b0},  // R4 upper edge inside
        '{10'd93,   10'd93,   12'd2179, 1'b1},  // R4 just below
        '{10'd689,  10'd689,  12'd2115, 1'b1},  // R4 just above
        '{10'd400,  10'd411,  12'd2117, 1'b0},  // R2 truncated average 405
        '{10'd0,    10'd1023, 12'd1949, 1'b0}   // R2 extreme mix, average 511
    };

    task automatic do_reset(input logic [11:0] ic, input logic [11:0] st);
        @(negedge clk);
        rst_n = 1'b0;
        init_code = ic;
        nudge_step = st;
        repeat (3) @(negedge clk);
        chk("R1 reset code", int'(dac_code), int'(ic));
        chk("R1 reset strobes", int'({dac_wr, done, retry}), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        do_reset(12'd2048, 12'd64);

        for (int v = 0; v < NV; v++) begin
            meas(VEC[v].a, VEC[v].b, 1'b0);
            chk($sformatf("R3/R4/R5/R6 vector %0d code", v), int'(last_code), int'(VEC[v].code));
            chk($sformatf("R11/R5 vector %0d retry", v), int'(last_retry), int'(VEC[v].rty));
        end

        // R10: samples while idle are ignored and produce nothing.
        begin
            int c0;
            c0 = done_cnt;
            for (int k = 0; k < 5; k++) begin
                det_valid = 1'b1;
                det_sample = 10'd1023;
                @(negedge clk);
                det_valid = 1'b0;
                @(negedge clk);
            end
            repeat (4) @(negedge clk);
            chk("R10 idle samples no done", done_cnt - c0, 0);
            chk("R10 idle samples code held", int'(dac_code), 1949);
            meas(10'd406, 10'd406, 1'b0);
            chk("R10 idle samples not averaged", int'(last_code), 1949);
        end

        // R9 and R10: slow envelope with early samples and a stray start.
        meas(10'd500, 10'd500, 1'b1);
        chk("R9 early samples dropped", int'(last_code), 1798);
        chk("R9 retry low", int'(last_retry), 0);

        // R7: saturation at the top.
        do_reset(12'd4000, 12'd200);
        meas(10'd50, 10'd50, 1'b0);
        chk("R7 nudge clamps at 4095", int'(last_code), 4095);
        chk("R5 retry on low reading", int'(last_retry), 1);
        meas(10'd94, 10'd94, 1'b0);
        chk("R7 correction clamps at 4095", int'(last_code), 4095);
        chk("R11 retry low inside", int'(last_retry), 0);

        // R7: saturation at the bottom.
        do_reset(12'd100, 12'd200);
        meas(10'd900, 10'd900, 1'b0);
        chk("R7 nudge clamps at 0", int'(last_code), 0);
        chk("R6 retry on high reading", int'(last_retry), 1);
        do_reset(12'd100, 12'd200);
        meas(10'd688, 10'd688, 1'b0);
        chk("R7 correction clamps at 0", int'(last_code), 0);

        finish_up();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        wait (cycles > 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
        finish_up();
    end

endmodule